// File: doc/BRIEF.md
# Parallel Printer Byte Sender

This block is the host side of a byte-wide printer link. A client hands it either a byte to print or a request to reset the printer, using a valid/ready handshake. For a byte, the block first waits until the printer reports that it is no longer busy. It then holds the byte on the data pins for a setup interval and drives the active-low strobe for a fixed time. After a hold interval it reports the result. For a reset request, it holds the active-low initialise line low for a long fixed time. Either way it finishes with a one-cycle done pulse and a status byte folded from the printer's five status pins.

All intervals are counted in clock cycles and set by parameters: setup, strobe width, hold, initialise width and the busy timeout. With a 50 MHz clock the defaults give a 0.6 µs strobe, 0.5 µs of setup and hold, a 300 µs initialise pulse and a 20 ms busy timeout. The select and autofeed outputs stay at their idle levels throughout.

Top module: `printerTx`

## Requirements
- R1: `cmdReady` is high exactly when no operation is in progress. A command is taken on a clock edge where `cmdValid` and `cmdReady` are both high. `cmdInit`=1 selects an initialise operation and `cmdInit`=0 selects a byte send. While `cmdReady` is low, `cmdValid` has no effect.
- R2: `selectN` is always 0 and `autoFeedN` is always 1. Outside their pulses, `strobeN` and `initN` are 1.
- R3: A byte send stays in its busy-wait phase while `busyIn` is 1. On the first clock edge where `busyIn` is sampled 0, the setup phase starts. `strobeN` falls after exactly `SETUP_CYC` setup cycles.
- R4: `dataOut` takes the byte on the edge where it is accepted. It then stays unchanged until the next byte is accepted, which covers the whole strobe and the `HOLD_CYC` cycles that follow it. An initialise operation leaves `dataOut` unchanged. `dataOut` is 0 after reset.
- R5: `strobeN` stays low for exactly `STROBE_CYC` cycles. It is followed by `HOLD_CYC` cycles before the operation ends. Once the busy-wait has ended, `busyIn` has no effect.
- R6: An initialise operation drives `initN` low for exactly `INIT_CYC` cycles, starting the cycle after acceptance. `strobeN` stays high during this time.
- R7: The status byte samples the pins on the edge that ends the operation. Its bit 7 is NOT `busyIn`, bit 6 is NOT `ackN`, bit 5 is `paperEnd`, bit 4 is `selectedIn` and bit 3 is NOT `errorN`. Bits 2..1 are 0, and bit 0 is the timeout flag.
- R8: If `busyIn` is sampled 1 on `TIMEOUT_CYC` consecutive busy-wait edges, the send ends without a strobe and status bit 0 is 1. Otherwise bit 0 is 0.
- R9: `doneValid` is a one-cycle pulse in the cycle after an operation ends. `cmdReady` rises in the following cycle. `doneStatus` holds its value until the next pulse, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command offered |
| cmdInit | input | 1 | 1 = initialise printer, 0 = send byte |
| cmdData | input | 8 | Byte to send |
| cmdReady | output | 1 | Block idle, command may be taken |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 8 | Folded status byte with timeout flag |
| dataOut | output | 8 | Data pins |
| strobeN | output | 1 | Active-low strobe pin |
| autoFeedN | output | 1 | Active-low autofeed pin, held inactive |
| initN | output | 1 | Active-low initialise pin |
| selectN | output | 1 | Active-low select pin, held asserted |
| busyIn | input | 1 | Printer busy pin, high = busy |
| ackN | input | 1 | Printer acknowledge pin, active low |
| paperEnd | input | 1 | Printer paper-out pin, high = out |
| selectedIn | input | 1 | Printer selected pin, high = selected |
| errorN | input | 1 | Printer error pin, active low |

## Verification
The bench builds the block with short intervals: setup 3, strobe 4, hold 2, initialise 12 and busy timeout 20 cycles. With these values every phase boundary, including a timeout and a busy release on the last wait cycle, fits within a few dozen clocks of a run. A behavioural model compares every output on every clock. That brings in reach both the busy release that lands exactly on the timeout edge and a command held valid across a whole operation.

// File: rtl/printerTxPkg.sv
package printerTxPkg;

  // one-hot phase encoding: each pin-driving phase is a single flop
  typedef enum logic [6:0] {
    ST_IDLE   = 7'b0000001,
    ST_WAIT   = 7'b0000010,
    ST_SETUP  = 7'b0000100,
    ST_STROBE = 7'b0001000,
    ST_HOLD   = 7'b0010000,
    ST_DONE   = 7'b0100000,
    ST_INIT   = 7'b1000000
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic clrCnt;
    logic capStatus;
    logic timedOut;
    logic strobeLow;
    logic initLow;
  } ctlStrobe_t;

  // raw status register image: S7 inverted from busy pin, others direct
  function automatic logic [7:0] rawStatus(input logic busyPin, input logic ackPin,
                                           input logic paperPin, input logic selPin,
                                           input logic errPin);
    return {~busyPin, ackPin, paperPin, selPin, errPin, 3'b000};
  endfunction

  // folded status: flip bits 6 and 3, append timeout flag in bit 0
  function automatic logic [7:0] foldStatus(input logic [7:0] raw, input logic timedOut);
    return (raw ^ 8'h48) | {7'b0, timedOut};
  endfunction

endpackage

// File: rtl/printerTxCtrl.sv
module printerTxCtrl
  import printerTxPkg::*;
#(
  parameter int SETUP_CYC   = 25,
  parameter int STROBE_CYC  = 30,
  parameter int HOLD_CYC    = 25,
  parameter int INIT_CYC    = 15000,
  parameter int TIMEOUT_CYC = 1000000,
  parameter int CNT_W       = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdInit,
  input  logic             busyIn,
  input  logic [CNT_W-1:0] cnt,
  output logic             cmdReady,
  output logic             doneValid,
  output ctlStrobe_t       ctl
);

  localparam logic [CNT_W-1:0] SETUP_LAST   = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LAST  = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST    = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] INIT_LAST    = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] TIMEOUT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  txState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    ctl           = '0;
    ctl.strobeLow = (state == ST_STROBE);
    ctl.initLow   = (state == ST_INIT);
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          ctl.clrCnt = 1'b1;
          if (cmdInit) begin
            nextState = ST_INIT;
          end else begin
            nextState    = ST_WAIT;
            ctl.loadData = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!busyIn) begin
          nextState  = ST_SETUP;
          ctl.clrCnt = 1'b1;
        end else if (cnt == TIMEOUT_LAST) begin
          nextState     = ST_DONE;
          ctl.capStatus = 1'b1;
          ctl.timedOut  = 1'b1;
        end
      end
      ST_SETUP: begin
        if (cnt == SETUP_LAST) begin
          nextState  = ST_STROBE;
          ctl.clrCnt = 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt == STROBE_LAST) begin
          nextState  = ST_HOLD;
          ctl.clrCnt = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt == HOLD_LAST) begin
          nextState     = ST_DONE;
          ctl.capStatus = 1'b1;
        end
      end
      ST_INIT: begin
        if (cnt == INIT_LAST) begin
          nextState     = ST_DONE;
          ctl.capStatus = 1'b1;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign cmdReady  = (state == ST_IDLE);
  assign doneValid = (state == ST_DONE);

  // independent strobe-width counter used only by the check below
  logic [CNT_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowRun <= '0;
    else if (ctl.strobeLow) lowRun <= lowRun + 1'b1;
    else                    lowRun <= '0;
  end

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.strobeLow && $past(ctl.strobeLow)) |-> lowRun == CNT_W'(STROBE_CYC)); // R5

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdReady) |-> $past(doneValid)); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && cmdReady)); // R9

endmodule

// File: rtl/printerTxData.sv
module printerTxData
  import printerTxPkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       cmdData,
  input  ctlStrobe_t       ctl,
  input  logic             busyIn,
  input  logic             ackN,
  input  logic             paperEnd,
  input  logic             selectedIn,
  input  logic             errorN,
  output logic [CNT_W-1:0] cnt,
  output logic [7:0]       dataOut,
  output logic             strobeN,
  output logic             initN,
  output logic             selectN,
  output logic             autoFeedN,
  output logic [7:0]       doneStatus
);

  logic [7:0] dataReg;
  logic [7:0] statusReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.clrCnt) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataReg <= '0;
    else if (ctl.loadData) dataReg <= cmdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusReg <= '0;
    else if (ctl.capStatus)
      statusReg <= foldStatus(rawStatus(busyIn, ackN, paperEnd, selectedIn, errorN),
                              ctl.timedOut);
  end

  assign dataOut    = dataReg;
  assign strobeN    = ~ctl.strobeLow;
  assign initN      = ~ctl.initLow;
  assign selectN    = 1'b0;
  assign autoFeedN  = 1'b1;
  assign doneStatus = statusReg;

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeN || $past(!strobeN)) |-> $stable(dataOut)); // R4

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!strobeN && !initN)); // R6

  AST_TIMEOUT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capStatus && ctl.timedOut) |-> busyIn); // R8

endmodule

// File: rtl/printerTx.sv
module printerTx
  import printerTxPkg::*;
#(
  parameter int SETUP_CYC   = 25,
  parameter int STROBE_CYC  = 30,
  parameter int HOLD_CYC    = 25,
  parameter int INIT_CYC    = 15000,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdInit,
  input  logic [7:0] cmdData,
  output logic       cmdReady,
  output logic       doneValid,
  output logic [7:0] doneStatus,
  output logic [7:0] dataOut,
  output logic       strobeN,
  output logic       autoFeedN,
  output logic       initN,
  output logic       selectN,
  input  logic       busyIn,
  input  logic       ackN,
  input  logic       paperEnd,
  input  logic       selectedIn,
  input  logic       errorN
);

  localparam int MAX_A   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_B   = (HOLD_CYC > INIT_CYC) ? HOLD_CYC : INIT_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_LEN = (MAX_C > TIMEOUT_CYC) ? MAX_C : TIMEOUT_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  ctlStrobe_t       ctl;
  logic [CNT_W-1:0] cnt;

  printerTxCtrl #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC),
    .INIT_CYC(INIT_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdInit(cmdInit),
    .busyIn(busyIn), .cnt(cnt), .cmdReady(cmdReady), .doneValid(doneValid),
    .ctl(ctl)
  );

  printerTxData #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .cmdData(cmdData), .ctl(ctl), .busyIn(busyIn),
    .ackN(ackN), .paperEnd(paperEnd), .selectedIn(selectedIn), .errorN(errorN),
    .cnt(cnt), .dataOut(dataOut), .strobeN(strobeN), .initN(initN),
    .selectN(selectN), .autoFeedN(autoFeedN), .doneStatus(doneStatus)
  );

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (strobeN && initN && !selectN && autoFeedN)); // R2

endmodule

// File: tb/printerTx_test.sv
module printerTx_test;

  localparam int SETUP   = 3;
  localparam int STROBE  = 4;
  localparam int HOLD    = 2;
  localparam int INITW   = 12;
  localparam int TIMEOUT = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdInit = 1'b0;
  logic [7:0] cmdData = 8'h00;
  logic busyIn = 1'b0, ackN = 1'b1, paperEnd = 1'b0, selectedIn = 1'b1, errorN = 1'b1;
  logic cmdReady, doneValid, strobeN, autoFeedN, initN, selectN;
  logic [7:0] doneStatus, dataOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  printerTx #(
    .SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .HOLD_CYC(HOLD),
    .INIT_CYC(INITW), .TIMEOUT_CYC(TIMEOUT)
  ) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdInit(cmdInit), .cmdData(cmdData),
    .cmdReady(cmdReady), .doneValid(doneValid), .doneStatus(doneStatus),
    .dataOut(dataOut), .strobeN(strobeN), .autoFeedN(autoFeedN), .initN(initN),
    .selectN(selectN), .busyIn(busyIn), .ackN(ackN), .paperEnd(paperEnd),
    .selectedIn(selectedIn), .errorN(errorN)
  );

  // behavioural model: phase name plus remaining-cycle countdown
  string      mPhase = "idle";
  int         mLeft = 0;
  int         mWaited = 0;
  logic [7:0] mData = 8'h00;
  logic [7:0] mStat = 8'h00;

  function automatic logic [7:0] expStatus(input logic to);
    return {~busyIn, ~ackN, paperEnd, selectedIn, ~errorN, 2'b00, to};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mPhase = "idle"; mData = 8'h00; mStat = 8'h00;
    end else begin
      if (mPhase == "idle") begin
        if (cmdValid) begin
          if (cmdInit) begin mPhase = "init"; mLeft = INITW; end
          else begin mPhase = "wait"; mWaited = 0; mData = cmdData; end
        end
      end else if (mPhase == "wait") begin
        if (!busyIn) begin mPhase = "setup"; mLeft = SETUP; end
        else if (mWaited == TIMEOUT - 1) begin mStat = expStatus(1'b1); mPhase = "done"; end
        else mWaited++;
      end else if (mPhase == "done") begin
        mPhase = "idle";
      end else begin
        mLeft--;
        if (mLeft == 0) begin
          if (mPhase == "setup") begin mPhase = "strobe"; mLeft = STROBE; end
          else if (mPhase == "strobe") begin mPhase = "hold"; mLeft = HOLD; end
          else begin mStat = expStatus(1'b0); mPhase = "done"; end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("R1", "cmdReady", {7'b0, cmdReady}, {7'b0, mPhase == "idle"});
      chk("R2", "selectN", {7'b0, selectN}, 8'h00);
      chk("R2", "autoFeedN", {7'b0, autoFeedN}, 8'h01);
      chk("R3 R5", "strobeN", {7'b0, strobeN}, {7'b0, mPhase != "strobe"});
      chk("R6", "initN", {7'b0, initN}, {7'b0, mPhase != "init"});
      chk("R4", "dataOut", dataOut, mData);
      chk("R9", "doneValid", {7'b0, doneValid}, {7'b0, mPhase == "done"});
      chk("R7 R8", "doneStatus", doneStatus, mStat);
    end
  end

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual running expected finished");
    summary();
  end

  task automatic issue(input logic isInit, input logic [7:0] b);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdInit = isInit; cmdData = b;
    @(negedge clk);
    cmdValid = 1'b0; cmdData = 8'h00;
  endtask

  task automatic waitDone;
    for (int i = 0; i < 200 && !doneValid; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state R9 R4 R1
    chk("R9", "reset doneStatus", doneStatus, 8'h00);
    chk("R4", "reset dataOut", dataOut, 8'h00);
    chk("R1", "reset cmdReady", {7'b0, cmdReady}, 8'h01);

    // R3 ready printer, plain byte
    issue(1'b0, 8'hA5);
    waitDone();
    chk("R7", "status ready printer", doneStatus, 8'h90);

    // R3 busy for a while, R1 extra valid ignored while busy
    busyIn = 1'b1;
    issue(1'b0, 8'h3C);
    cmdValid = 1'b1; cmdData = 8'hFF;
    repeat (6) @(negedge clk);
    cmdValid = 1'b0; cmdData = 8'h00;
    busyIn = 1'b0;
    waitDone();
    chk("R1", "dataOut kept first byte", dataOut, 8'h3C);

    // R8 timeout
    busyIn = 1'b1; ackN = 1'b0;
    issue(1'b0, 8'h81);
    waitDone();
    chk("R8", "timeout status", doneStatus, 8'h51);
    busyIn = 1'b0; ackN = 1'b1;

    // R8 busy released on the last wait edge: no timeout
    busyIn = 1'b1;
    issue(1'b0, 8'h66);
    repeat (TIMEOUT - 1) @(negedge clk);
    busyIn = 1'b0;
    waitDone();
    chk("R8", "late release no timeout", doneStatus, 8'h90);

    // R6 init with R7 odd pin pattern, R4 data unchanged
    paperEnd = 1'b1; errorN = 1'b0; selectedIn = 1'b0; ackN = 1'b0;
    issue(1'b1, 8'hEE);
    waitDone();
    chk("R7", "init status", doneStatus, 8'hE8);
    chk("R4", "init keeps data", dataOut, 8'h66);
    paperEnd = 1'b0; errorN = 1'b1; selectedIn = 1'b1; ackN = 1'b1;

    // R5 busy rising after wait has ended is ignored
    issue(1'b0, 8'h5A);
    repeat (3) @(negedge clk);
    busyIn = 1'b1;
    waitDone();
    busyIn = 1'b0;

    // R9 back-to-back commands with valid held high
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdInit = 1'b0; cmdData = 8'h12;
    @(negedge clk);
    cmdData = 8'h34;
    for (int i = 0; i < 200 && !doneValid; i++) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 200 && !doneValid; i++) @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
    chk("R9", "second byte sent", dataOut, 8'h34);

    repeat (5) @(negedge clk);
    summary();
  end

endmodule